// File: doc/BRIEF.md
# Configuration Access Window Sequencer

This block carries out one bus configuration read or write on behalf of a host by borrowing the address translator's local-to-bus windows for a moment. A request gives a bus number, a device/function number, a register offset, an access size and, for writes, the data. The sequencer then issues a fixed series of translator register writes. Window 0 is grown so that it covers the region window 1 normally serves. Window 1 is then pointed at a 16 MB configuration aperture and given the configuration cycle type. The access runs through that aperture. Afterwards window 1 is restored to prefetchable memory, and only then is window 0 shrunk back.

The configuration address is formed inside the block. On bus 0 a one-hot device select is used. For low slot numbers it sits in the address. For high slot numbers it moves into the map word that is written to window 1. On any other bus the bus and device/function numbers are placed in the address, and the low address bits are passed through. The block returns the read data with a one-cycle done pulse, and it shows busy for the whole borrowed-window interval.

Top module: `cfg_window_seq`

## Requirements
- R1: While reset is applied and after it is released, busy, done, err, reg_we and acc_valid are all 0.
- R2: In the three cycles after a legal request is accepted, reg_we is 1 and the block writes three registers in order. First reg_sel=0 (window 0 base) with 0x4000_0091: base bits 31:20, size code 9 (512 MB) in bits 7:4, enable in bit 0. Next reg_sel=1 (window 1 base) with 0x6100_0041 (size code 4, 16 MB). Last reg_sel=2 (window 1 map) with the formed map word in bits 15:0.
- R3: For bus 0 with slot (devfn bits 7:3) of 12 or less, acc_addr is 0x6100_0000 + (1 << (slot+11)) + (function << 8) + offset. The map word is 0x000A: type 5 in bits 3:1, low-address-enable bit 0 clear.
- R4: For bus 0 with slot above 12, acc_addr carries no device bit. The map word is 0x000A OR (1 << (slot-5)), truncated to 16 bits, so slots above 20 set no select bit.
- R5: For a nonzero bus, acc_addr is 0x6100_0000 + (bus << 16) + (devfn << 8) + offset, and the map word is 0x000B (low-address-enable set).
- R6: After the open writes, acc_valid is held with a stable address, a stable write flag and size code until acc_ready. The size code is 0, 1 or 2 for 1, 2 or 4 bytes. For a write, acc_wdata carries the request data.
- R7: A write access is followed at once by a read (acc_write=0) of the same address and size before any close write.
- R8: After the access, three consecutive writes restore the windows. First reg_sel=1 with 0x5000_0081 (size code 8, 256 MB). Next reg_sel=2 with 0x0000_100C (bus address 0x1000_0000, type 6 in bits 3:1). Last reg_sel=0 with 0x4000_0081.
- R9: A request is illegal when bus, devfn or offset is above 255 or the size code is 3. An illegal request causes no register write and no access. It produces done and err together for one cycle, in the cycle after acceptance.
- R10: busy is 1 from the cycle after a legal acceptance through the last close write. A request presented while busy is ignored.
- R11: done is a one-cycle pulse in the cycle after the last close write, with err 0. rdata then holds the data returned by the last completed access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | Request present; taken when busy is 0 |
| req_write | input | 1 | 1 for a configuration write |
| req_bus | input | FIELD_W | Bus number |
| req_devfn | input | FIELD_W | Device (bits 7:3) and function (bits 2:0) |
| req_offset | input | FIELD_W | Register offset |
| req_size | input | 2 | 0: 1 byte, 1: 2 bytes, 2: 4 bytes, 3: illegal |
| req_wdata | input | DATA_W | Write data |
| busy | output | 1 | Windows borrowed; new requests ignored |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | With done: request was illegal |
| rdata | output | DATA_W | Data of the last completed access |
| reg_we | output | 1 | Translator register write strobe |
| reg_sel | output | 2 | 0 window 0 base, 1 window 1 base, 2 window 1 map |
| reg_wdata | output | 32 | Translator register value |
| acc_valid | output | 1 | Access request toward the bus |
| acc_write | output | 1 | Access direction |
| acc_addr | output | 32 | Local address inside the configuration aperture |
| acc_size | output | 2 | Access size code |
| acc_wdata | output | DATA_W | Access write data |
| acc_ready | input | 1 | Access completes in this cycle |
| acc_rdata | input | DATA_W | Access read data, valid with acc_ready |

## Verification
The bench builds the block with FIELD_W of 10. This lets it present bus, device/function and offset values from 256 up to 1023, which reaches the illegal-request path next to the largest legal request (all fields 255). The window bases keep their defaults. The bench varies the access latency from one to three cycles, which exercises the hold-until-ready behaviour and the write-then-read-back pair at several lengths. It drives slots 9, 12, 13 and 20 on bus 0 to cover both sides of the split between address and map device selects.

// File: rtl/cfgw_pkg.sv
package cfgw_pkg;

  typedef enum logic [3:0] {
    S_IDLE,
    S_OPEN0,
    S_OPEN1,
    S_OPENMAP,
    S_ACC,
    S_RDBK,
    S_CLOSE1,
    S_CLOSEMAP,
    S_CLOSE0
  } seq_state_e;

  // translator register selects
  localparam logic [1:0] SEL_W0_BASE = 2'd0;
  localparam logic [1:0] SEL_W1_BASE = 2'd1;
  localparam logic [1:0] SEL_W1_MAP  = 2'd2;

  // window size codes
  localparam logic [3:0] SZ_16M  = 4'd4;
  localparam logic [3:0] SZ_256M = 4'd8;
  localparam logic [3:0] SZ_512M = 4'd9;

  // map cycle kinds
  localparam logic [2:0] MAP_T_CFG      = 3'd5;
  localparam logic [2:0] MAP_T_MEMMULTI = 3'd6;

  localparam logic [1:0] SIZE_BAD = 2'd3;

  // base word: address bits 31:20, size code 7:4, enable bit 0
  function automatic logic [31:0] base_word(input logic [11:0] hi, input logic [3:0] size_code);
    base_word = {hi, 12'h000, size_code, 3'b000, 1'b1};
  endfunction

  // map word: bus address bits 31:20, kind 3:1, low-address-enable bit 0
  function automatic logic [15:0] map_word(input logic [11:0] hi, input logic [2:0] kind, input logic low_en);
    map_word = {hi, kind, low_en};
  endfunction

endpackage

// File: rtl/cfgw_addr_form.sv
module cfgw_addr_form
  import cfgw_pkg::*;
#(
  parameter int          FIELD_W      = 10,
  parameter int          FIELD_MAX    = 255,
  parameter logic [31:0] CFG_WIN_BASE = 32'h6100_0000
) (
  input  logic [FIELD_W-1:0] bus,
  input  logic [FIELD_W-1:0] devfn,
  input  logic [FIELD_W-1:0] offset,
  input  logic [1:0]         size,
  output logic               legal,
  output logic [31:0]        addr,
  output logic [15:0]        map
);

  localparam logic [FIELD_W-1:0] LIM = FIELD_W'(FIELD_MAX);
  localparam int SLOT_SPLIT = 12;
  localparam int DEV_LO     = 11;
  localparam int MAP_SHIFT  = 5;

  logic [4:0]  slot;
  logic [2:0]  func;
  logic [31:0] slot_w;
  logic [31:0] dev_off;
  logic [15:0] map_sel;

  assign slot   = devfn[7:3];
  assign func   = devfn[2:0];
  assign slot_w = {27'd0, slot};

  always_comb begin
    legal   = (bus <= LIM) && (devfn <= LIM) && (offset <= LIM) && (size != SIZE_BAD);
    map_sel = 16'd1 << (slot - 5'(MAP_SHIFT));
    if (bus == '0) begin
      // type-0: one-hot select split between address and map
      dev_off = {21'd0, func, 8'd0};
      if (slot_w <= 32'(SLOT_SPLIT)) begin
        dev_off = dev_off | (32'd1 << (slot_w + 32'(DEV_LO)));
        map     = map_word(12'h000, MAP_T_CFG, 1'b0);
      end else begin
        map     = map_word(12'h000, MAP_T_CFG, 1'b0) | map_sel;
      end
    end else begin
      // type-1: bus and devfn in the address, low bits passed through
      dev_off = {8'd0, bus[7:0], devfn[7:0], 8'd0};
      map     = map_word(12'h000, MAP_T_CFG, 1'b1);
    end
    addr = CFG_WIN_BASE + dev_off + {24'd0, offset[7:0]};
  end

endmodule

// File: rtl/cfgw_seq_fsm.sv
module cfgw_seq_fsm
  import cfgw_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       legal,
  input  logic       is_write,
  input  logic       acc_ready,
  output seq_state_e state,
  output logic       done,
  output logic       err
);

  seq_state_e state_d;
  logic       done_d;
  logic       err_d;

  always_comb begin
    state_d = state;
    done_d  = 1'b0;
    err_d   = 1'b0;
    unique case (state)
      S_IDLE: begin
        if (start) begin
          if (legal) begin
            state_d = S_OPEN0;
          end else begin
            done_d = 1'b1;
            err_d  = 1'b1;
          end
        end
      end
      S_OPEN0:    state_d = S_OPEN1;
      S_OPEN1:    state_d = S_OPENMAP;
      S_OPENMAP:  state_d = S_ACC;
      S_ACC: begin
        if (acc_ready) state_d = is_write ? S_RDBK : S_CLOSE1;
      end
      S_RDBK: begin
        if (acc_ready) state_d = S_CLOSE1;
      end
      S_CLOSE1:   state_d = S_CLOSEMAP;
      S_CLOSEMAP: state_d = S_CLOSE0;
      S_CLOSE0: begin
        state_d = S_IDLE;
        done_d  = 1'b1;
      end
      default:    state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE;
      done  <= 1'b0;
      err   <= 1'b0;
    end else begin
      state <= state_d;
      done  <= done_d;
      err   <= err_d;
    end
  end

endmodule

// File: rtl/cfgw_port_drive.sv
module cfgw_port_drive
  import cfgw_pkg::*;
#(
  parameter int          DATA_W          = 32,
  parameter logic [31:0] MEM_WIN_BASE    = 32'h4000_0000,
  parameter logic [31:0] MEM_WIN_SPAN    = 32'h1000_0000,
  parameter logic [31:0] CFG_WIN_BASE    = 32'h6100_0000,
  parameter logic [31:0] PREMEM_BUS_BASE = 32'h1000_0000
) (
  input  seq_state_e        state,
  input  logic [31:0]       lat_addr,
  input  logic [15:0]       lat_map,
  input  logic              lat_write,
  input  logic [1:0]        lat_size,
  input  logic [DATA_W-1:0] lat_wdata,
  output logic              reg_we,
  output logic [1:0]        reg_sel,
  output logic [31:0]       reg_wdata,
  output logic              acc_valid,
  output logic              acc_write,
  output logic [31:0]       acc_addr,
  output logic [1:0]        acc_size,
  output logic [DATA_W-1:0] acc_wdata
);

  localparam logic [31:0] PREMEM_LOCAL = MEM_WIN_BASE + MEM_WIN_SPAN;
  localparam logic [31:0] W0_WIDE      = base_word(MEM_WIN_BASE[31:20], SZ_512M);
  localparam logic [31:0] W0_NORMAL    = base_word(MEM_WIN_BASE[31:20], SZ_256M);
  localparam logic [31:0] W1_CFG       = base_word(CFG_WIN_BASE[31:20], SZ_16M);
  localparam logic [31:0] W1_NORMAL    = base_word(PREMEM_LOCAL[31:20], SZ_256M);
  localparam logic [15:0] MAP_PREMEM   = map_word(PREMEM_BUS_BASE[31:20], MAP_T_MEMMULTI, 1'b0);

  always_comb begin
    reg_we    = 1'b1;
    reg_sel   = SEL_W0_BASE;
    reg_wdata = '0;
    unique case (state)
      S_OPEN0:    begin reg_sel = SEL_W0_BASE; reg_wdata = W0_WIDE;              end
      S_OPEN1:    begin reg_sel = SEL_W1_BASE; reg_wdata = W1_CFG;               end
      S_OPENMAP:  begin reg_sel = SEL_W1_MAP;  reg_wdata = {16'h0000, lat_map};   end
      S_CLOSE1:   begin reg_sel = SEL_W1_BASE; reg_wdata = W1_NORMAL;            end
      S_CLOSEMAP: begin reg_sel = SEL_W1_MAP;  reg_wdata = {16'h0000, MAP_PREMEM}; end
      S_CLOSE0:   begin reg_sel = SEL_W0_BASE; reg_wdata = W0_NORMAL;            end
      default:    reg_we = 1'b0;
    endcase
  end

  always_comb begin
    acc_valid = (state == S_ACC) || (state == S_RDBK);
    acc_write = (state == S_ACC) && lat_write;
    acc_addr  = lat_addr;
    acc_size  = lat_size;
    acc_wdata = lat_wdata;
  end

endmodule

// File: rtl/cfg_window_seq.sv
module cfg_window_seq
  import cfgw_pkg::*;
#(
  parameter int          FIELD_W         = 10,
  parameter int          DATA_W          = 32,
  parameter logic [31:0] MEM_WIN_BASE    = 32'h4000_0000,
  parameter logic [31:0] MEM_WIN_SPAN    = 32'h1000_0000,
  parameter logic [31:0] CFG_WIN_BASE    = 32'h6100_0000,
  parameter logic [31:0] PREMEM_BUS_BASE = 32'h1000_0000
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  input  logic               req_write,
  input  logic [FIELD_W-1:0] req_bus,
  input  logic [FIELD_W-1:0] req_devfn,
  input  logic [FIELD_W-1:0] req_offset,
  input  logic [1:0]         req_size,
  input  logic [DATA_W-1:0]  req_wdata,
  output logic               busy,
  output logic               done,
  output logic               err,
  output logic [DATA_W-1:0]  rdata,
  output logic               reg_we,
  output logic [1:0]         reg_sel,
  output logic [31:0]        reg_wdata,
  output logic               acc_valid,
  output logic               acc_write,
  output logic [31:0]        acc_addr,
  output logic [1:0]         acc_size,
  output logic [DATA_W-1:0]  acc_wdata,
  input  logic               acc_ready,
  input  logic [DATA_W-1:0]  acc_rdata
);

  logic [1:0]        rst_pipe;
  logic              rst_core_n;
  seq_state_e        state;
  logic              start;
  logic              accept;
  logic              legal;
  logic [31:0]       form_addr;
  logic [15:0]       form_map;
  logic [31:0]       lat_addr;
  logic [15:0]       lat_map;
  logic              lat_write;
  logic [1:0]        lat_size;
  logic [DATA_W-1:0] lat_wdata;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_core_n = rst_pipe[1];

  assign busy   = (state != S_IDLE);
  assign start  = req_valid && !busy;
  assign accept = start && legal;

  cfgw_addr_form #(
    .FIELD_W      (FIELD_W),
    .FIELD_MAX    (255),
    .CFG_WIN_BASE (CFG_WIN_BASE)
  ) u_form (
    .bus    (req_bus),
    .devfn  (req_devfn),
    .offset (req_offset),
    .size   (req_size),
    .legal  (legal),
    .addr   (form_addr),
    .map    (form_map)
  );

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      lat_addr  <= '0;
      lat_map   <= '0;
      lat_write <= 1'b0;
      lat_size  <= '0;
      lat_wdata <= '0;
    end else if (accept) begin
      lat_addr  <= form_addr;
      lat_map   <= form_map;
      lat_write <= req_write;
      lat_size  <= req_size;
      lat_wdata <= req_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n)                  rdata <= '0;
    else if (acc_valid && acc_ready)  rdata <= acc_rdata;
  end

  cfgw_seq_fsm u_fsm (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .start     (start),
    .legal     (legal),
    .is_write  (lat_write),
    .acc_ready (acc_ready),
    .state     (state),
    .done      (done),
    .err       (err)
  );

  cfgw_port_drive #(
    .DATA_W          (DATA_W),
    .MEM_WIN_BASE    (MEM_WIN_BASE),
    .MEM_WIN_SPAN    (MEM_WIN_SPAN),
    .CFG_WIN_BASE    (CFG_WIN_BASE),
    .PREMEM_BUS_BASE (PREMEM_BUS_BASE)
  ) u_drive (
    .state     (state),
    .lat_addr  (lat_addr),
    .lat_map   (lat_map),
    .lat_write (lat_write),
    .lat_size  (lat_size),
    .lat_wdata (lat_wdata),
    .reg_we    (reg_we),
    .reg_sel   (reg_sel),
    .reg_wdata (reg_wdata),
    .acc_valid (acc_valid),
    .acc_write (acc_write),
    .acc_addr  (acc_addr),
    .acc_size  (acc_size),
    .acc_wdata (acc_wdata)
  );

endmodule

// File: rtl/cfg_window_seq_chk.sv
module cfg_window_seq_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        busy,
  input logic        done,
  input logic        err,
  input logic        reg_we,
  input logic [1:0]  reg_sel,
  input logic [31:0] reg_wdata,
  input logic        acc_valid,
  input logic        acc_write,
  input logic        acc_ready,
  input logic [31:0] acc_addr
);

  // R2: first busy cycle widens window 0
  assert_open_first_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> (reg_we && reg_sel == 2'd0 && reg_wdata[7:4] == 4'd9));

  // R8: window 1 map restore is followed directly by the window 0 shrink
  assert_close_order_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_sel == 2'd2 && reg_wdata[3:1] == 3'd6)
      |=> (reg_we && reg_sel == 2'd0 && reg_wdata[7:4] == 4'd8));

  // R6: access held stable until ready
  assert_acc_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && !acc_ready) |=> (acc_valid && $stable(acc_addr) && $stable(acc_write)));

  // R7: a completed write is followed by a read of the same address
  assert_readback_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && acc_ready && acc_write) |=> (acc_valid && !acc_write && $stable(acc_addr)));

  // R10: port activity only while busy, never both ports together
  assert_ports_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we || acc_valid) |-> busy);
  assert_ports_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_we && acc_valid));

  // R9: err only alongside done
  assert_err_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> (done && !busy));

  // R11: done is a single pulse unless an illegal request follows at once
  assert_done_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !err) |=> (!done || err));

endmodule

bind cfg_window_seq cfg_window_seq_chk u_chk (.*);

// File: tb/cfg_window_seq_bench.sv
`timescale 1ns/1ps
module cfg_window_seq_bench;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, req_write;
  logic [9:0]  req_bus, req_devfn, req_offset;
  logic [1:0]  req_size;
  logic [31:0] req_wdata;
  logic        busy, done, err;
  logic [31:0] rdata;
  logic        reg_we;
  logic [1:0]  reg_sel;
  logic [31:0] reg_wdata;
  logic        acc_valid, acc_write;
  logic [31:0] acc_addr;
  logic [1:0]  acc_size;
  logic [31:0] acc_wdata;
  logic        acc_ready;
  logic [31:0] acc_rdata;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  cfg_window_seq #(.FIELD_W(10), .DATA_W(32)) u_cfg_window_seq (.*);

  typedef struct packed {
    logic        we;
    logic [1:0]  sel;
    logic [31:0] rw;
    logic        av;
    logic        aw;
    logic [31:0] aa;
    logic [1:0]  asz;
    logic [31:0] ad;
    logic        bsy;
    logic        dn;
    logic        er;
    logic        chkrd;
    logic [31:0] rd;
    logic        rdy;
    logic [31:0] give;
    logic        poke;
  } exp_t;

  exp_t  q[$];
  string tq[$];
  int    poke_at;

  function automatic exp_t idle_e();
    exp_t e;
    e = '0;
    return e;
  endfunction

  function automatic void push(exp_t e, string t);
    exp_t x;
    x = e;
    if (q.size() == poke_at) x.poke = 1'b1;
    q.push_back(x);
    tq.push_back(t);
  endfunction

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic cmp(exp_t e, string t);
    chk({t, " R10"}, "busy", {31'd0, busy}, {31'd0, e.bsy});
    chk({t, " R11"}, "done", {31'd0, done}, {31'd0, e.dn});
    chk({t, " R9"},  "err",  {31'd0, err},  {31'd0, e.er});
    chk(t, "reg_we", {31'd0, reg_we}, {31'd0, e.we});
    if (e.we) begin
      chk(t, "reg_sel",   {30'd0, reg_sel}, {30'd0, e.sel});
      chk(t, "reg_wdata", reg_wdata, e.rw);
    end
    chk(t, "acc_valid", {31'd0, acc_valid}, {31'd0, e.av});
    if (e.av) begin
      chk(t, "acc_write", {31'd0, acc_write}, {31'd0, e.aw});
      chk(t, "acc_addr",  acc_addr, e.aa);
      chk({t, " R6"}, "acc_size", {30'd0, acc_size}, {30'd0, e.asz});
      if (e.aw) chk({t, " R6"}, "acc_wdata", acc_wdata, e.ad);
    end
    if (e.chkrd) chk({t, " R11"}, "rdata", rdata, e.rd);
  endtask

  // Runs the queued expectations, one per clock, comparing at the negedge
  task automatic drain();
    exp_t  e;
    string t;
    while (q.size() > 0) begin
      @(negedge clk);
      e = q.pop_front();
      t = tq.pop_front();
      cmp(e, t);
      req_valid = e.poke;
      if (e.poke) begin
        req_write  = 1'b0;
        req_bus    = 10'd0;
        req_devfn  = 10'h048;
        req_offset = 10'd0;
        req_size   = 2'd2;
      end
      acc_ready = e.rdy;
      acc_rdata = e.give;
    end
  endtask

  task automatic idle_cycles(int n, string t);
    poke_at = -1;
    for (int i = 0; i < n; i++) push(idle_e(), t);
    drain();
  endtask

  // Called at a negedge with the design idle
  task automatic run_req(bit w, int bus, int devfn, int off, int sz, logic [31:0] wd,
                         int lat, logic [31:0] give, int poke);
    exp_t        e;
    bit          legal;
    int          slot, func;
    logic [31:0] a;
    logic [15:0] mp;
    string       ft;
    legal = (bus <= 255) && (devfn <= 255) && (off <= 255) && (sz != 3);
    poke_at    = poke;
    req_valid  = 1'b1;
    req_write  = w;
    req_bus    = 10'(bus);
    req_devfn  = 10'(devfn);
    req_offset = 10'(off);
    req_size   = 2'(sz);
    req_wdata  = wd;
    slot = (devfn >> 3) & 31;
    func = devfn & 7;
    if (bus == 0) begin
      a = 32'(func << 8);
      if (slot <= 12) begin
        a  = a | (32'd1 << (slot + 11));
        mp = 16'h000A;
        ft = "R3";
      end else begin
        mp = 16'h000A | 16'((32'd1 << (slot - 5)) & 32'hFFFF);
        ft = "R4";
      end
    end else begin
      a  = 32'((bus << 16) | (devfn << 8));
      mp = 16'h000B;
      ft = "R5";
    end
    a = 32'h6100_0000 + a + 32'(off);
    if (legal) begin
      e = idle_e(); e.bsy = 1; e.we = 1;
      e.sel = 2'd0; e.rw = 32'h4000_0091; push(e, "R2");
      e.sel = 2'd1; e.rw = 32'h6100_0041; push(e, "R2");
      e.sel = 2'd2; e.rw = {16'h0000, mp}; push(e, {"R2 ", ft});
      e = idle_e(); e.bsy = 1; e.av = 1; e.aw = w; e.aa = a; e.asz = 2'(sz); e.ad = wd;
      for (int i = 0; i < lat; i++) begin
        e.rdy  = (i == lat - 1);
        e.give = e.rdy ? (w ? 32'h0BAD_0BAD : give) : 32'h0;
        push(e, {ft, " R6"});
      end
      if (w) begin
        e.aw = 0;
        for (int i = 0; i < lat; i++) begin
          e.rdy  = (i == lat - 1);
          e.give = e.rdy ? give : 32'h0;
          push(e, "R7");
        end
      end
      e = idle_e(); e.bsy = 1; e.we = 1;
      e.sel = 2'd1; e.rw = 32'h5000_0081; push(e, "R8");
      e.sel = 2'd2; e.rw = 32'h0000_100C; push(e, "R8");
      e.sel = 2'd0; e.rw = 32'h4000_0081; push(e, "R8");
      e = idle_e(); e.dn = 1; e.chkrd = 1; e.rd = give; push(e, "R11");
      push(idle_e(), "R11");
    end else begin
      e = idle_e(); e.dn = 1; e.er = 1; push(e, "R9");
      push(idle_e(), "R9");
    end
    drain();
  endtask

  initial begin
    rst_n      = 1'b0;
    req_valid  = 1'b0;
    req_write  = 1'b0;
    req_bus    = '0;
    req_devfn  = '0;
    req_offset = '0;
    req_size   = '0;
    req_wdata  = '0;
    acc_ready  = 1'b0;
    acc_rdata  = '0;
    poke_at    = -1;
    idle_cycles(3, "R1");
    rst_n = 1'b1;
    idle_cycles(4, "R1");

    // R3: bus 0, slot 9 function 2, 4-byte read, single-cycle access
    run_req(0, 0, (9 << 3) | 2, 8'h10, 2, 32'h0, 1, 32'h1234_5678, -1);
    // R3 boundary: slot 12, byte read, latency 3, poke while busy (R10)
    run_req(0, 0, (12 << 3), 8'hFC, 0, 32'h0, 3, 32'h0000_00A5, 4);
    // R4: slot 13, 2-byte read
    run_req(0, 0, (13 << 3) | 1, 4, 1, 32'h0, 2, 32'hCAFE_0001, -1);
    // R4: slot 20 sets map bit 15
    run_req(0, 0, (20 << 3) | 7, 8'h40, 2, 32'h0, 1, 32'h0000_BEEF, -1);
    // R5: nonzero bus
    run_req(0, 5, 8'h4B, 8'h20, 2, 32'h0, 1, 32'h8086_1234, 2);
    // R7: write with read-back, poke during open (R10)
    run_req(1, 0, (10 << 3) | 3, 8'h3C, 2, 32'hA5A5_5A5A, 2, 32'hA5A5_5A5A, 1);
    // largest legal fields, byte write
    run_req(1, 255, 255, 255, 0, 32'h0000_0077, 1, 32'h0000_0077, -1);
    // R9: each illegal field in turn
    run_req(0, 256, 8, 0, 2, 32'h0, 1, 32'h0, -1);
    run_req(0, 0, 300, 0, 2, 32'h0, 1, 32'h0, -1);
    run_req(1, 0, 8, 256, 2, 32'h1, 1, 32'h0, -1);
    run_req(0, 0, 8, 0, 3, 32'h0, 1, 32'h0, -1);
    // legal after illegal; rdata from this access (R11)
    run_req(0, 1, 8'h08, 0, 2, 32'h0, 2, 32'h5555_AAAA, -1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL R10 watchdog actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule